// File: doc/BRIEF.md
# Keyed-Restart Watchdog Timer

This block is a watchdog for a system-on-chip. Software programs a reload value and a control word over a 32-bit register port that uses single-cycle read and write strobes. Once enabled, a down-counter decrements on a selectable tick: either a fast peripheral tick or a slow 1 MHz tick. Software keeps the system alive by writing a 16-bit key to a restart register, which reloads the counter. Any other value written there does nothing.

When the counter runs out, the block stops counting. It then takes one of two paths. If the inhibit input is high at that moment, it clears its control register and does nothing else. Otherwise it can emit a system-reset pulse, an interrupt pulse, or both. The reset pulse lasts a programmed number of slow ticks. Its polarity and drive type are switched by writing special values in the top byte of the pulse configuration register. A control write takes effect only when it changes the enable state.

Top module: `wdog_keyed`

## Requirements
- R1: After reset, the count and reload registers read 0x03EF1480, control reads 0, pulse configuration reads 0x000000FF and reset mask reads 0. rstOut is 1 and rstOe is 0 (active-low, open-drain, idle), and irqOut is 0.
- R2: Byte offsets are decoded as follows: 0x00 is the current count (read-only), 0x04 is reload, 0x08 is restart (reads 0), 0x0C is control, 0x18 is pulse configuration and 0x1C is reset mask. Any other offset reads 0 and ignores writes.
- R3: An access whose address bits [1:0] are not 00 reads 0 and changes no register.
- R4: A restart write whose low 16 bits are 0x4755 loads the count from reload and resumes counting if control bit 0 is set. A restart write with any other value has no effect.
- R5: A control write with bit 0 = 1 while bit 0 is currently 0 stores the word, loads the count from reload and starts counting.
- R6: A control write with bit 0 = 0 while bit 0 is currently 1 stores the word and stops counting. A control write that keeps bit 0 unchanged is discarded.
- R7: Control bit 4 selects the tick: 0 selects tickFast and 1 selects tickSlow. The count decrements by one per selected tick and ignores the other tick. The tick on which the count reaches 0 is the expiry. At expiry the count stays 0 and counting stops.
- R8: At expiry with inhibit low and control bit 1 set, the reset output is asserted for N tickSlow pulses, where N is the pulse configuration field bits [19:0].
- R9: At expiry with inhibit low and control bit 2 set, irqOut is high for exactly one clock cycle.
- R10: At expiry with inhibit high, control is cleared to 0, no reset pulse is issued and no interrupt is raised.
- R11: In a pulse configuration write, the top byte controls two bits. 0xA5 sets bit 31 (active-high) and 0x5A clears it. 0xA8 sets bit 30 (push-pull) and 0x8A clears it. Any other top byte leaves both bits unchanged.
- R12: A pulse configuration write updates only bits [19:0]. Bits [29:20] keep their previous values.
- R13: The asserted reset level is 1 when bit 31 is set and 0 when it is clear. rstOe is always 1 in push-pull mode (bit 30 = 1). In open-drain mode it is 1 only while the reset is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Single-cycle write strobe |
| rdEn | input | 1 | Read strobe; rdData is valid in the same cycle |
| addr | input | 8 | Byte address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data; 0 when rdEn is low |
| tickFast | input | 1 | Peripheral-rate tick enable |
| tickSlow | input | 1 | 1 MHz tick enable |
| inhibit | input | 1 | Suppresses the timeout action when high at expiry |
| rstOut | output | 1 | System reset level |
| rstOe | output | 1 | Output enable for rstOut |
| irqOut | output | 1 | Timeout interrupt pulse |

## Verification
The assertions rely on three assumptions about the inputs:
- The strobes and ticks are one-cycle pulses sampled at the rising edge.
- Address and data are stable while wrEn is high.
- inhibit is low in the cycles where the control-write and misaligned-write properties are checked. This is because an inhibited expiry is allowed to clear control.

The bench drives every input on the falling edge and holds inhibit low except in the single inhibited-expiry scenario. During the randomized phase the timer is left disabled, so the count changes only through keyed restarts. The bench model can therefore predict the count exactly.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_COUNT  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_RELOAD = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_KICK   = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_PULSE  = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_MASK   = 8'h1C;

  localparam int CB_EN   = 0;
  localparam int CB_RST  = 1;
  localparam int CB_IRQ  = 2;
  localparam int CB_SLOW = 4;

  localparam int PB_HIGH = 31;
  localparam int PB_PUSH = 30;

  localparam logic [7:0] TAG_HIGH_SET  = 8'hA5;
  localparam logic [7:0] TAG_HIGH_CLR  = 8'h5A;
  localparam logic [7:0] TAG_PUSH_SET  = 8'hA8;
  localparam logic [7:0] TAG_PUSH_CLR  = 8'h8A;

  typedef struct packed {
    logic kick;
    logic start;
    logic stop;
  } wdStrobe_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PW_W = 20,
  parameter logic [15:0] KEY = 16'h4755,
  parameter logic [CNT_W-1:0] RESET_COUNT = 'h03EF1480
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [CNT_W-1:0]  cntVal,
  input  logic              clrCtrl,
  output wdStrobe_t         strobe,
  output logic [CNT_W-1:0]  reloadVal,
  output logic [DATA_W-1:0] ctrlVal,
  output logic [DATA_W-1:0] widthVal,
  output logic [DATA_W-1:0] maskVal,
  output logic [DATA_W-1:0] rdData
);
  logic aligned, wrHit;
  logic hiBit, pushBit;
  logic [DATA_W-1:0] widthNext;

  assign aligned = (addr[1:0] == 2'b00);
  assign wrHit   = wrEn && aligned;

  always_comb begin
    strobe.kick  = wrHit && (addr == OFS_KICK) && (wrData[15:0] == KEY);
    strobe.start = wrHit && (addr == OFS_CTRL) && wrData[CB_EN] && !ctrlVal[CB_EN];
    strobe.stop  = wrHit && (addr == OFS_CTRL) && !wrData[CB_EN] && ctrlVal[CB_EN];
  end

  always_comb begin
    hiBit   = widthVal[PB_HIGH];
    pushBit = widthVal[PB_PUSH];
    case (wrData[31:24])
      TAG_HIGH_SET: hiBit   = 1'b1;
      TAG_HIGH_CLR: hiBit   = 1'b0;
      TAG_PUSH_SET: pushBit = 1'b1;
      TAG_PUSH_CLR: pushBit = 1'b0;
      default: ;
    endcase
    widthNext = {hiBit, pushBit, widthVal[29:PW_W], wrData[PW_W-1:0]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reloadVal <= RESET_COUNT;
      ctrlVal   <= '0;
      widthVal  <= 32'h0000_00FF;
      maskVal   <= '0;
    end else begin
      if (wrHit && addr == OFS_RELOAD) reloadVal <= wrData[CNT_W-1:0];
      if (strobe.start || strobe.stop) ctrlVal <= wrData;
      else if (clrCtrl)                ctrlVal <= '0;
      if (wrHit && addr == OFS_PULSE)  widthVal <= widthNext;
      if (wrHit && addr == OFS_MASK)   maskVal <= wrData;
    end
  end

  always_comb begin
    rdData = '0;
    if (rdEn && aligned) begin
      case (addr)
        OFS_COUNT:  rdData = DATA_W'(cntVal);
        OFS_RELOAD: rdData = DATA_W'(reloadVal);
        OFS_CTRL:   rdData = ctrlVal;
        OFS_PULSE:  rdData = widthVal;
        OFS_MASK:   rdData = maskVal;
        default:    rdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PW_W = 20,
  parameter logic [CNT_W-1:0] RESET_COUNT = 'h03EF1480
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdStrobe_t        strobe,
  input  logic [CNT_W-1:0] reloadVal,
  input  logic             enBit,
  input  logic             rstSysBit,
  input  logic             irqBit,
  input  logic             slowSel,
  input  logic [PW_W-1:0]  pulseWidth,
  input  logic             activeHigh,
  input  logic             pushPull,
  input  logic             tickFast,
  input  logic             tickSlow,
  input  logic             inhibit,
  output logic [CNT_W-1:0] cntVal,
  output logic             clrCtrl,
  output logic             rstOut,
  output logic             rstOe,
  output logic             irqOut
);
  logic running, tick, anyStrobe, hit, fire, pulseOn;
  logic [PW_W-1:0] pulseCnt;

  assign tick      = slowSel ? tickSlow : tickFast;
  assign anyStrobe = strobe.kick || strobe.start || strobe.stop;
  assign hit       = running && tick && !anyStrobe && (cntVal <= CNT_W'(1));
  assign clrCtrl   = hit && inhibit;
  assign fire      = hit && !inhibit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntVal  <= RESET_COUNT;
      running <= 1'b0;
    end else if (strobe.kick) begin
      cntVal  <= reloadVal;
      running <= enBit;
    end else if (strobe.start) begin
      cntVal  <= reloadVal;
      running <= 1'b1;
    end else if (strobe.stop) begin
      running <= 1'b0;
    end else if (running && tick) begin
      if (cntVal <= CNT_W'(1)) begin
        cntVal  <= '0;
        running <= 1'b0;
      end else begin
        cntVal <= cntVal - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseCnt <= '0;
      irqOut   <= 1'b0;
    end else begin
      irqOut <= fire && irqBit;
      if (fire && rstSysBit)               pulseCnt <= pulseWidth;
      else if (pulseOn && tickSlow)        pulseCnt <= pulseCnt - 1'b1;
    end
  end

  assign pulseOn = (pulseCnt != '0);
  assign rstOut  = activeHigh ? pulseOn : !pulseOn;
  assign rstOe   = pushPull || pulseOn;
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
  import wdog_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PW_W = 20,
  parameter logic [15:0] KEY = 16'h4755,
  parameter logic [CNT_W-1:0] RESET_COUNT = 'h03EF1480
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [7:0]  addr,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  input  logic        tickFast,
  input  logic        tickSlow,
  input  logic        inhibit,
  output logic        rstOut,
  output logic        rstOe,
  output logic        irqOut
);
  wdStrobe_t strobe;
  logic [CNT_W-1:0] cntVal, reloadVal;
  logic [DATA_W-1:0] ctrlVal, widthVal, maskVal;
  logic clrCtrl;

  wdog_regs #(.CNT_W(CNT_W), .PW_W(PW_W), .KEY(KEY), .RESET_COUNT(RESET_COUNT)) regs_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .cntVal(cntVal), .clrCtrl(clrCtrl), .strobe(strobe), .reloadVal(reloadVal),
    .ctrlVal(ctrlVal), .widthVal(widthVal), .maskVal(maskVal), .rdData(rdData)
  );

  wdog_core #(.CNT_W(CNT_W), .PW_W(PW_W), .RESET_COUNT(RESET_COUNT)) core_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reloadVal(reloadVal),
    .enBit(ctrlVal[CB_EN]), .rstSysBit(ctrlVal[CB_RST]), .irqBit(ctrlVal[CB_IRQ]),
    .slowSel(ctrlVal[CB_SLOW]), .pulseWidth(widthVal[PW_W-1:0]),
    .activeHigh(widthVal[PB_HIGH]), .pushPull(widthVal[PB_PUSH]),
    .tickFast(tickFast), .tickSlow(tickSlow), .inhibit(inhibit),
    .cntVal(cntVal), .clrCtrl(clrCtrl), .rstOut(rstOut), .rstOe(rstOe), .irqOut(irqOut)
  );
endmodule

// File: rtl/wdog_keyed_chk.sv
module wdog_keyed_chk #(
  parameter int CNT_W = 32,
  parameter int PW_W = 20,
  parameter logic [15:0] KEY = 16'h4755
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [7:0]       addr,
  input logic [31:0]      wrData,
  input logic             inhibit,
  input logic             irqOut,
  input logic             rstOut,
  input logic             rstOe,
  input logic [CNT_W-1:0] cntVal,
  input logic [CNT_W-1:0] reloadVal,
  input logic [31:0]      ctrlVal,
  input logic [31:0]      widthVal,
  input logic [31:0]      maskVal
);
  p_kick_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 8'h08 && wrData[15:0] == KEY) |=> (cntVal == $past(reloadVal)));

  p_ctrl_same_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 8'h0C && wrData[0] == ctrlVal[0] && !inhibit) |=> $stable(ctrlVal));

  p_misaligned_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr[1:0] != 2'b00 && !inhibit) |=>
      ($stable(reloadVal) && $stable(ctrlVal) && $stable(widthVal) && $stable(maskVal)));

  p_width_keep_r12: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 8'h18) |=> (widthVal[29:PW_W] == $past(widthVal[29:PW_W])));

  p_irq_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |=> !irqOut);

  p_irq_inhibit_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> !$past(inhibit));

  p_idle_level_r13: assert property (@(posedge clk) disable iff (!rstN)
    !rstOe |-> (rstOut != widthVal[31]));
endmodule

bind wdog_keyed wdog_keyed_chk #(.CNT_W(CNT_W), .PW_W(PW_W), .KEY(KEY)) chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData), .inhibit(inhibit),
  .irqOut(irqOut), .rstOut(rstOut), .rstOe(rstOe), .cntVal(cntVal), .reloadVal(reloadVal),
  .ctrlVal(ctrlVal), .widthVal(widthVal), .maskVal(maskVal)
);

// File: tb/wdog_keyed_tb_top.sv
module wdog_keyed_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic tickFast = 1'b0, tickSlow = 1'b0, inhibit = 1'b0;
  logic rstOut, rstOe, irqOut;
  int nChecks = 0;
  int nFails = 0;

  wdog_keyed dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .tickFast(tickFast), .tickSlow(tickSlow), .inhibit(inhibit),
    .rstOut(rstOut), .rstOe(rstOe), .irqOut(irqOut)
  );

  always #4 clk = ~clk;

  function automatic logic [31:0] keyWord(input logic [15:0] hi);
    return {hi, 16'h4755};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    #1 d = rdData;
    rdEn = 1'b0;
  endtask

  task automatic tickF(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tickFast = 1'b1;
      @(negedge clk); tickFast = 1'b0;
    end
  endtask

  task automatic tickS(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tickSlow = 1'b1;
      @(negedge clk); tickSlow = 1'b0;
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    nFails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [31:0] d, v, k, mReload, mCnt;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(8'h00, d); check("R1 count", d, 32'h03EF1480);
    rd(8'h04, d); check("R1 reload", d, 32'h03EF1480);
    rd(8'h0C, d); check("R1 ctrl", d, 32'h0);
    rd(8'h18, d); check("R1 pulse cfg", d, 32'h000000FF);
    rd(8'h1C, d); check("R1 mask", d, 32'h0);
    check("R1 rstOut idle", {31'b0, rstOut}, 32'd1);
    check("R1 rstOe idle", {31'b0, rstOe}, 32'd0);
    check("R1 irq", {31'b0, irqOut}, 32'd0);

    // R2 decode
    rd(8'h08, d); check("R2 restart reads 0", d, 32'h0);
    wr(8'h10, 32'hFFFF_FFFF); rd(8'h10, d); check("R2 unmapped", d, 32'h0);
    wr(8'h1C, 32'hDEADBEEF); rd(8'h1C, d); check("R2 mask rw", d, 32'hDEADBEEF);

    // R3 misaligned
    wr(8'h05, 32'h1234_5678); rd(8'h04, d); check("R3 misaligned write", d, 32'h03EF1480);
    rd(8'h06, d); check("R3 misaligned read", d, 32'h0);

    // R4 randomized key / reload traffic with timer disabled
    mReload = 32'h03EF1480; mCnt = 32'h03EF1480;
    for (int i = 0; i < 40; i++) begin
      case ($urandom_range(0, 2))
        0: begin v = $urandom; wr(8'h04, v); mReload = v; end
        1: begin
          v = $urandom;
          k = ($urandom_range(0, 1) == 1) ? keyWord(v[31:16]) : v;
          if (k[15:0] == 16'h4755) mCnt = mReload;
          wr(8'h08, k);
        end
        default: begin v = $urandom; wr(8'h04 + 8'($urandom_range(1, 3)), v); end
      endcase
      rd(8'h00, d); check("R4 count model", d, mCnt);
      rd(8'h04, d); check("R3 reload model", d, mReload);
    end
    wr(8'h08, 32'h0000_4756); rd(8'h00, d); check("R4 wrong key", d, mCnt);

    // R5/R7 counting on fast tick
    wr(8'h04, 32'd10);
    wr(8'h0C, 32'h01); rd(8'h00, d); check("R5 start loads", d, 32'd10);
    tickF(3); rd(8'h00, d); check("R7 fast decrement", d, 32'd7);
    tickS(2); rd(8'h00, d); check("R7 slow ignored", d, 32'd7);
    // R6 discarded write
    wr(8'h0C, 32'h13); rd(8'h0C, d); check("R6 same enable discarded", d, 32'h01);
    wr(8'h0C, 32'h00); rd(8'h0C, d); check("R6 stop stores", d, 32'h00);
    tickF(2); rd(8'h00, d); check("R6 stopped", d, 32'd7);
    // R7 slow select
    wr(8'h0C, 32'h11); tickS(2); rd(8'h00, d); check("R7 slow decrement", d, 32'd8);
    tickF(2); rd(8'h00, d); check("R7 fast ignored", d, 32'd8);
    wr(8'h08, keyWord(16'hABCD)); rd(8'h00, d); check("R4 kick running", d, 32'd10);
    tickS(1); rd(8'h00, d); check("R4 resumes", d, 32'd9);
    wr(8'h0C, 32'h00);

    // R8/R9 expiry
    wr(8'h18, 32'h0000_0004);
    wr(8'h04, 32'd3);
    wr(8'h0C, 32'h07);
    tickF(2);
    check("R8 not yet", {31'b0, rstOut}, 32'd1);
    tickF(1);
    check("R9 irq high", {31'b0, irqOut}, 32'd1);
    check("R8 reset asserted low", {31'b0, rstOut}, 32'd0);
    check("R13 oe while asserted", {31'b0, rstOe}, 32'd1);
    @(negedge clk);
    check("R9 irq one cycle", {31'b0, irqOut}, 32'd0);
    rd(8'h00, d); check("R7 count zero", d, 32'd0);
    tickS(3); check("R8 still asserted", {31'b0, rstOut}, 32'd0);
    tickS(1); check("R8 released", {31'b0, rstOut}, 32'd1);
    check("R13 open drain idle", {31'b0, rstOe}, 32'd0);
    tickF(2); rd(8'h00, d); check("R7 stopped after expiry", d, 32'd0);
    rd(8'h0C, d); check("R8 ctrl kept", d, 32'h07);

    // R10 inhibit
    wr(8'h0C, 32'h00);
    wr(8'h04, 32'd2);
    inhibit = 1'b1;
    wr(8'h0C, 32'h07);
    tickF(2);
    check("R10 no irq", {31'b0, irqOut}, 32'd0);
    check("R10 no reset", {31'b0, rstOut}, 32'd1);
    rd(8'h0C, d); check("R10 ctrl cleared", d, 32'h0);
    inhibit = 1'b0;
    tickS(2); check("R10 still no reset", {31'b0, rstOut}, 32'd1);

    // R11/R12/R13 pulse configuration
    wr(8'h18, 32'hA500_0010); rd(8'h18, d); check("R11 A5 sets high", d, 32'h8000_0010);
    check("R13 active-high idle level", {31'b0, rstOut}, 32'd0);
    wr(8'h18, 32'hA800_0010); rd(8'h18, d); check("R11 A8 sets push", d, 32'hC000_0010);
    check("R13 push-pull oe", {31'b0, rstOe}, 32'd1);
    wr(8'h18, 32'h5A00_0010); rd(8'h18, d); check("R11 5A clears high", d, 32'h4000_0010);
    wr(8'h18, 32'h12FF_FFFF); rd(8'h18, d); check("R12 low field only", d, 32'h400F_FFFF);
    wr(8'h18, 32'h8A00_0003); rd(8'h18, d); check("R11 8A clears push", d, 32'h0000_0003);

    finishRun();
  end
endmodule